// File: doc/BRIEF.md
# Multi-Mode 32-Bit Serial Word Shifter

This block is one shift register that software loads and collects as a plain word, in either bit order. It shifts through one data lane, in the way a standard SPI port does, or through four lanes at once, so that each shift moves a nibble. The word keeps the same bit layout in both cases. Shift timing comes from an external rate generator that pulses `tick` at twice the bit rate. The shifter acts on every second tick, which leaves the other half-bit free to act as a sampling offset.

There are two sub-modes. In transfer mode a written word is shifted out while the word on the input lanes is shifted in. The half-bit phase runs freely while the block is enabled, so a new load lines up with the clock edges already in progress. In capture mode a `start` pulse, not a pin edge, starts free-running sampling with no start or stop bits. The first sample is taken on the first tick after `start`, and sampling goes on until the block is disabled. A further `start` discards the partial word and re-aligns the phase. Each full word appears on `rd_data` with a one-cycle `word_valid` pulse. The `overrun` flag shows that a word was replaced before software acknowledged it.

Top module: `serial_word_shifter`

## Requirements
- R1: After reset, `sd_out`, `busy`, `word_valid` and `overrun` are 0.
- R2: In single-lane, MSB-first order (`cfg_quad_i`=0, `cfg_lsb_i`=0), word bit 31 goes out on `sd_out[0]` first. The first bit sampled from `sd_in[0]` lands in `rd_data[31]`. `sd_out[3:1]` stay 0, and `sd_in[3:1]` are ignored.
- R3: In single-lane, LSB-first order (`cfg_lsb_i`=1), word bit 0 goes out first, and the first sampled bit lands in `rd_data[0]`.
- R4: In quad mode (`cfg_quad_i`=1), each shift moves four bits with `sd_out[3]` as the most significant. MSB-first sends bits [31:28] first. LSB-first sends bits [3:0] first. Received nibbles are placed at the same positions as the ones sent, so no nibbles are reordered.
- R5: While enabled, the half-bit phase alternates on every `tick`. A shift happens only on a tick that starts a bit. In transfer mode, a write does not reset this phase.
- R6: After 32 single-lane shifts or 8 quad shifts, `rd_data` holds the assembled word and `word_valid` is high for exactly one cycle. In transfer mode `busy` then falls.
- R7: In capture mode (`cfg_capture_i`=1), `start` clears the phase. The first sample is taken on the first tick after `start` and then on every second tick. Words are delivered back to back for as long as the block stays enabled.
- R8: A `start` during capture discards the partial word, so the next word is built only from samples taken after that `start`.
- R9: `overrun` is set when a word is delivered while the previous one has not been acknowledged by `rd_ack`. It is cleared by `rd_ack`.
- R10: The mode inputs are latched only while `en` is low. Changing them while enabled has no effect.
- R11: A write while `busy` is high is ignored, and the current word keeps shifting.
- R12: Dropping `en` ends any transfer or capture at once: `busy` and `sd_out` go to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable. The mode is latched while this is low. |
| tick | input | 1 | Half-bit pulse from the rate generator |
| cfg_quad_i | input | 1 | 1 = four lanes, 0 = one lane |
| cfg_lsb_i | input | 1 | 1 = LSB-first, 0 = MSB-first |
| cfg_capture_i | input | 1 | 1 = software-started capture, 0 = transfer |
| wr_valid | input | 1 | Load strobe for `wr_data` (transfer mode, idle only) |
| wr_data | input | WIDTH | Word to send |
| start | input | 1 | Starts or restarts capture |
| sd_in | input | LANES | Serial input lanes |
| rd_ack | input | 1 | Software has taken `rd_data` |
| sd_out | output | LANES | Serial output lanes. 0 when not transferring. |
| busy | output | 1 | Transfer in progress |
| rd_data | output | WIDTH | Last completed word |
| word_valid | output | 1 | One-cycle pulse when a word completes |
| overrun | output | 1 | A word was replaced before it was acknowledged |

## Verification
The assertions check on every cycle that:
- unused lanes stay quiet in single-lane mode;
- the latched mode does not move while the block is enabled;
- `word_valid` is a single-cycle pulse that follows a tick;
- `overrun` only rises together with a delivery;
- the output lanes hold between ticks and writes;
- disabling the block leaves it idle.

Only the bench scenarios can show the rest:
- bit and nibble placement in all four lane and order combinations;
- that a load keeps the running phase;
- that capture samples on the half-bit after `start`;
- that a restart discards a partial word;
- that writes made while busy are ignored.

// File: rtl/serial_word_shifter.sv
`timescale 1ns/1ps
module serial_word_shifter #(
  parameter int WIDTH = 32,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             cfg_quad_i,
  input  logic             cfg_lsb_i,
  input  logic             cfg_capture_i,
  input  logic             wr_valid,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             start,
  input  logic [LANES-1:0] sd_in,
  input  logic             rd_ack,
  output logic [LANES-1:0] sd_out,
  output logic             busy,
  output logic [WIDTH-1:0] rd_data,
  output logic             word_valid,
  output logic             overrun
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_SINGLE = CW'(WIDTH - 1);
  localparam logic [CW-1:0] LAST_QUAD   = CW'(WIDTH / LANES - 1);

  logic [WIDTH-1:0] sh, sh_next;
  logic [CW-1:0]    cnt;
  logic             phase, run_q, pend_q;
  logic             cfg_quad_q, cfg_lsb_q, cfg_cap_q;

  wire go     = en & cfg_cap_q & start;
  wire load   = en & ~cfg_cap_q & ~busy & wr_valid;
  wire active = cfg_cap_q ? run_q : busy;
  wire step   = en & tick & ~phase & active & ~go & ~load;
  wire last   = (cnt == (cfg_quad_q ? LAST_QUAD : LAST_SINGLE));
  wire done   = step & last;

  always_comb begin
    case ({cfg_quad_q, cfg_lsb_q})
      2'b00:   sh_next = {sh[WIDTH-2:0], sd_in[0]};
      2'b01:   sh_next = {sd_in[0], sh[WIDTH-1:1]};
      2'b10:   sh_next = {sh[WIDTH-LANES-1:0], sd_in};
      default: sh_next = {sd_in, sh[WIDTH-1:LANES]};
    endcase
  end

  logic [LANES-1:0] head;
  always_comb begin
    if (cfg_quad_q)
      head = cfg_lsb_q ? sh[LANES-1:0] : sh[WIDTH-1 -: LANES];
    else
      head = {{(LANES-1){1'b0}}, (cfg_lsb_q ? sh[0] : sh[WIDTH-1])};
  end
  assign sd_out = busy ? head : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; cnt <= '0; phase <= 1'b0; busy <= 1'b0; run_q <= 1'b0;
      cfg_quad_q <= 1'b0; cfg_lsb_q <= 1'b0; cfg_cap_q <= 1'b0;
    end else if (!en) begin
      cnt <= '0; phase <= 1'b0; busy <= 1'b0; run_q <= 1'b0;
      cfg_quad_q <= cfg_quad_i; cfg_lsb_q <= cfg_lsb_i; cfg_cap_q <= cfg_capture_i;
    end else begin
      if (go)        phase <= 1'b0;
      else if (tick) phase <= ~phase;
      if (go) begin
        sh <= '0; cnt <= '0; run_q <= 1'b1;
      end else if (load) begin
        sh <= wr_data; cnt <= '0; busy <= 1'b1;
      end else if (step) begin
        sh  <= sh_next;
        cnt <= last ? '0 : cnt + 1'b1;
        if (last && !cfg_cap_q) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0; word_valid <= 1'b0; pend_q <= 1'b0; overrun <= 1'b0;
    end else begin
      word_valid <= done;
      if (done) rd_data <= sh_next;
      if (done)        pend_q <= 1'b1;
      else if (rd_ack) pend_q <= 1'b0;
      if (done && pend_q && !rd_ack) overrun <= 1'b1;
      else if (rd_ack)               overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_word_shifter_chk.sv
`timescale 1ns/1ps
module serial_word_shifter_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic             wr_valid,
  input logic             start,
  input logic [LANES-1:0] sd_out,
  input logic             busy,
  input logic             word_valid,
  input logic             overrun,
  input logic             cfg_quad,
  input logic             cfg_lsb,
  input logic             cfg_cap
);
  a_r2_upper_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_quad |-> sd_out[LANES-1:1] == '0);

  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> $stable({cfg_quad, cfg_lsb, cfg_cap}));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  a_r6_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(en && tick));

  a_r9_overrun_on_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> word_valid);

  a_r5_lanes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && !$past(tick) && !$past(wr_valid) && !$past(start)) |-> $stable(sd_out));

  a_r12_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!busy && sd_out == '0));
endmodule

bind serial_word_shifter serial_word_shifter_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .wr_valid(wr_valid),
  .start(start), .sd_out(sd_out), .busy(busy), .word_valid(word_valid),
  .overrun(overrun), .cfg_quad(cfg_quad_q), .cfg_lsb(cfg_lsb_q), .cfg_cap(cfg_cap_q)
);

// File: tb/serial_word_shifter_tb_top.sv
`timescale 1ns/1ps
module serial_word_shifter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, tick = 0, cfg_quad_i = 0, cfg_lsb_i = 0, cfg_capture_i = 0;
  logic wr_valid = 0, start = 0, rd_ack = 0;
  logic [31:0] wr_data = '0;
  logic [3:0]  sd_in = '0;
  logic [3:0]  sd_out;
  logic        busy, word_valid, overrun;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_shifter dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cfg_quad_i(cfg_quad_i),
    .cfg_lsb_i(cfg_lsb_i), .cfg_capture_i(cfg_capture_i), .wr_valid(wr_valid),
    .wr_data(wr_data), .start(start), .sd_in(sd_in), .rd_ack(rd_ack),
    .sd_out(sd_out), .busy(busy), .rd_data(rd_data), .word_valid(word_valid),
    .overrun(overrun)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] unit_of(input logic [31:0] w, input int i, input bit q, input bit l);
    if (!q) return l ? {3'b000, w[i]} : {3'b000, w[31-i]};
    return l ? w[4*i +: 4] : w[31-4*i -: 4];
  endfunction

  function automatic logic [3:0] drive_of(input logic [31:0] w, input int i, input bit q, input bit l);
    logic [3:0] u = unit_of(w, i, q, l);
    if (!q) u[3:1] = 3'($urandom);
    return u;
  endfunction

  task automatic do_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) rd_ack = 1;
    @(negedge clk) rd_ack = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic set_mode(input bit q, input bit l, input bit c);
    @(negedge clk) en = 0;
    cfg_quad_i = q; cfg_lsb_i = l; cfg_capture_i = c;
    @(negedge clk) en = 1;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk) wr_valid = 1; wr_data = w;
    @(negedge clk) wr_valid = 0;
  endtask

  task automatic run_sync(input logic [31:0] tx, input logic [31:0] rx, input bit q, input bit l,
                          input bit ack, input string tag);
    int n = q ? 8 : 32;
    int bad = 0;
    logic [31:0] bad_act = '0, bad_exp = '0;
    write_word(tx);
    check(busy == 1'b1, {tag, " busy after write"}, 32'(busy), 32'd1);
    for (int i = 0; i < n; i++) begin
      if (sd_out != unit_of(tx, i, q, l) && bad == 0) begin
        bad++; bad_act = 32'(sd_out); bad_exp = 32'(unit_of(tx, i, q, l));
      end
      sd_in = drive_of(rx, i, q, l);
      do_tick();
      if (i < n - 1) check(word_valid == 1'b0, {tag, " no early valid"}, 32'(word_valid), 0);
      sd_in = ~sd_in;
      if (i == n - 1) begin
        check(word_valid == 1'b1, {tag, " R6 word_valid"}, 32'(word_valid), 32'd1);
        check(rd_data == rx, {tag, " rx word"}, rd_data, rx);
        check(busy == 1'b0, {tag, " R6 busy falls"}, 32'(busy), 0);
      end
      do_tick();
    end
    check(bad == 0, {tag, " tx lane order"}, bad_act, bad_exp);
    check(word_valid == 1'b0, {tag, " R6 one-cycle pulse"}, 32'(word_valid), 0);
    if (ack) pulse_ack();
  endtask

  task automatic run_cap(input logic [31:0] rx, input bit q, input bit l, input string tag);
    int n = q ? 8 : 32;
    for (int i = 0; i < n; i++) begin
      sd_in = drive_of(rx, i, q, l);
      do_tick();
      sd_in = ~sd_in;
      if (i == n - 1) begin
        check(word_valid == 1'b1, {tag, " R7 word_valid"}, 32'(word_valid), 32'd1);
        check(rd_data == rx, {tag, " R7 captured word"}, rd_data, rx);
      end
      do_tick();
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(sd_out == 4'h0 && busy == 0 && word_valid == 0 && overrun == 0,
          "R1 reset state", {sd_out, busy, word_valid, overrun}, 0);
    rst_n = 1;
    @(negedge clk);

    // Directed and random transfers in every lane/order combination
    set_mode(0, 0, 0);
    run_sync(32'h8000_0001, 32'hC000_0003, 0, 0, 1, "R2 directed");
    for (int k = 0; k < 3; k++) run_sync($urandom, $urandom, 0, 0, 1, "R2 random");
    set_mode(0, 1, 0);
    run_sync(32'h8000_0001, 32'h0000_0006, 0, 1, 1, "R3 directed");
    for (int k = 0; k < 3; k++) run_sync($urandom, $urandom, 0, 1, 1, "R3 random");
    set_mode(1, 0, 0);
    run_sync(32'h1234_5678, 32'h9ABC_DEF0, 1, 0, 1, "R4 quad msb");
    for (int k = 0; k < 3; k++) run_sync($urandom, $urandom, 1, 0, 1, "R4 quad msb random");
    set_mode(1, 1, 0);
    run_sync(32'h1234_5678, 32'h9ABC_DEF0, 1, 1, 1, "R4 quad lsb");
    for (int k = 0; k < 3; k++) run_sync($urandom, $urandom, 1, 1, 1, "R4 quad lsb random");

    // R11: write while busy is ignored
    begin
      logic [31:0] tx = 32'hA5A5_0F0F;
      set_mode(0, 0, 0);
      write_word(tx);
      sd_in = 0; do_tick(); do_tick();
      write_word(32'h0000_0000);
      check(sd_out == unit_of(tx, 1, 0, 0), "R11 write while busy ignored", 32'(sd_out), 32'(unit_of(tx, 1, 0, 0)));
      do_tick(); do_tick();
      check(sd_out == unit_of(tx, 2, 0, 0), "R11 original word continues", 32'(sd_out), 32'(unit_of(tx, 2, 0, 0)));
    end

    // R12 disable ends the transfer
    @(negedge clk) en = 0;
    @(negedge clk);
    check(busy == 0 && sd_out == 0, "R12 disable idles", {sd_out, busy}, 0);

    // R5 write keeps phase
    begin
      logic [31:0] tx = 32'h4000_0000;
      set_mode(0, 0, 0);
      do_tick();
      write_word(tx);
      check(sd_out == 4'h0, "R5 head bit after write", 32'(sd_out), 0);
      do_tick();
      check(sd_out == 4'h0 && busy == 1, "R5 no shift on mid-bit tick", {sd_out, busy}, 32'h1);
      do_tick();
      check(sd_out == 4'h1, "R5 shift on next bit tick", 32'(sd_out), 32'h1);
    end

    // R10 mode inputs ignored while enabled
    set_mode(0, 0, 0);
    cfg_quad_i = 1; cfg_lsb_i = 1; cfg_capture_i = 1;
    run_sync(32'hF00D_CAFE, 32'h1357_9BDF, 0, 0, 1, "R10 mode frozen");

    // R9 overrun
    set_mode(0, 0, 0);
    run_sync($urandom, 32'h1111_1111, 0, 0, 0, "R9 first");
    check(overrun == 0, "R9 no overrun on first", 32'(overrun), 0);
    run_sync($urandom, 32'h2222_2222, 0, 0, 0, "R9 second");
    check(overrun == 1, "R9 overrun set", 32'(overrun), 1);
    pulse_ack();
    check(overrun == 0, "R9 overrun cleared by ack", 32'(overrun), 0);

    // R7 capture: start resyncs phase, continuous words
    set_mode(0, 0, 1);
    do_tick();
    pulse_start();
    run_cap(32'hDEAD_BEEF, 0, 0, "R7 single msb");
    pulse_ack();
    run_cap($urandom, 0, 0, "R7 continuous");
    pulse_ack();
    set_mode(1, 1, 1);
    do_tick();
    pulse_start();
    for (int k = 0; k < 3; k++) begin
      run_cap($urandom, 1, 1, "R7 quad lsb");
      pulse_ack();
    end

    // R8 restart discards partial word
    set_mode(0, 1, 1);
    pulse_start();
    for (int i = 0; i < 5; i++) begin
      sd_in = 4'hF; do_tick(); do_tick();
    end
    do_tick();
    pulse_start();
    run_cap(32'h0F1E_2D3C, 0, 1, "R8 restart");
    pulse_ack();

    @(negedge clk) en = 0;
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule